// File: doc/BRIEF.md
# Keyed Watchdog Interval Timer

This block is an 8-bit up-counter driven by a selectable clock prescaler. Software can use it as a periodic interval timer or as a watchdog that has to be refreshed. It keeps a control/status byte and a count byte, and both are written through one shared 16-bit write port. The upper byte of each write is a key. Key 0xA5 directs the lower byte into the control/status byte. Key 0x5A directs it into the count byte. Any other key leaves the block unchanged, so a stray or corrupted store cannot start, stop or refresh the timer.

While counting is enabled, the prescaler accumulates system-clock cycles that are qualified by `clk_en`. Each time it completes a period it advances the counter by one. When the counter steps past its maximum it wraps to zero and raises a one-cycle interrupt request. That request carries a priority level and a vector number, both taken from configuration inputs. Either byte can be read back through a byte-wide read port.

A small state machine follows the timer. Its states are ST_STOP (counting disabled), ST_RUN (counting) and ST_FIRE (the cycle that follows an overflow, in which the request is presented). Its transitions are:
- ST_STOP→ST_RUN on a keyed control write with the enable bit set.
- ST_RUN→ST_STOP and ST_FIRE→ST_STOP on a keyed control write with the enable bit clear.
- ST_RUN→ST_FIRE on an overflow.
- ST_FIRE→ST_RUN after one cycle.
- ST_FIRE→ST_FIRE if another overflow occurs at once, which is only possible in principle.

Top module: `keyed_wdt`

## Requirements
- R1: A write whose bits [15:8] equal 0xA5 loads bits [7:0] into the control/status byte on that clock edge.
- R2: A write whose bits [15:8] equal 0x5A loads bits [7:0] into the count byte on that clock edge.
- R3: A write with any other value in bits [15:8] changes neither byte and does not disturb the prescaler.
- R4: Control bits [2:0] select the prescale period in `clk_en`-qualified cycles: code 0 gives 2, and code n (1 to 7) gives 32<<n.
- R5: Control bit 5 enables counting. While it is clear, the count byte changes only by a keyed count write.
- R6: When a prescaler period completes with the count at 0xFF, the count becomes 0x00 and `irq_req` is high for exactly the following cycle.
- R7: During the `irq_req` cycle, `irq_level` equals bits [7:4] of `prio_cfg` and `irq_vector` equals bits [6:0] of `vec_cfg`, both sampled at the overflow edge. Outside that cycle both are zero.
- R8: A keyed control write clears the prescaler accumulation, and no count occurs on that edge. The next count comes one full period after the write.
- R9: Cycles with `clk_en` low do not advance the prescaler.
- R10: A keyed count write on the same edge as a completed prescaler period wins, and that period's increment is lost.
- R11: After reset both bytes read zero, counting is disabled and `irq_req` is low.
- R12: `rd_data` shows the control/status byte when `rd_sel` is 0 and the count byte when `rd_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Qualifies cycles the prescaler may accumulate |
| wr_en | input | 1 | Write strobe for the keyed port |
| wr_data | input | 16 | Key in [15:8], payload in [7:0] |
| rd_sel | input | 1 | Read select: 0 control/status, 1 count |
| rd_data | output | 8 | Selected register byte |
| prio_cfg | input | 8 | Priority register; upper nibble is the interrupt level |
| vec_cfg | input | 8 | Vector register; low 7 bits are the interrupt vector |
| irq_req | output | 1 | One-cycle overflow interrupt request |
| irq_level | output | 4 | Interrupt level, valid while `irq_req` is high |
| irq_vector | output | 7 | Interrupt vector, valid while `irq_req` is high |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 3-bit clock-select field and a base shift of 5. With these values every prescale code from the 2-cycle special case up to the 4096-cycle period is reachable inside a short run. A preload of 0xFF brings overflow of even the slowest setting within a few thousand cycles. The same-edge collisions between a count write and a prescaler period, and between a control write and an active accumulation, can be placed on exact edges because the shortest period is two cycles.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } kwdt_state_e;
endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec #(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] KEY_CSR = 8'hA5,
    parameter logic [DATA_W-1:0] KEY_CNT = 8'h5A
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_key,
    output logic              csr_we,
    output logic              cnt_we
);
    // Each register answers to exactly one key; all other keys are dropped.
    always_comb begin
        csr_we = wr_en && (wr_key == KEY_CSR);
        cnt_we = wr_en && (wr_key == KEY_CNT);
    end
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
    parameter int SEL_W      = 3,
    parameter int BASE_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             clk_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int               PRE_W = BASE_SHIFT + (1 << SEL_W);
    localparam logic [PRE_W-1:0] ONE   = 1;

    logic [PRE_W-1:0] acc_q;
    logic [PRE_W-1:0] limit;

    // Code 0 is the exception: a period of two cycles, not a shifted base.
    always_comb begin
        if (sel == '0) begin
            limit = ONE;
        end else begin
            limit = (ONE << (BASE_SHIFT + int'(sel))) - ONE;
        end
        tick = run && clk_en && (acc_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (run && clk_en) begin
            acc_q <= tick ? '0 : acc_q + ONE;
        end
    end
endmodule

// File: rtl/kwdt_fsm.sv
module kwdt_fsm
    import kwdt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int EN_BIT = 5,
    parameter int LVL_W  = 4,
    parameter int VEC_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wr_lo,
    input  logic              tick,
    input  logic [DATA_W-1:0] prio_cfg,
    input  logic [DATA_W-1:0] vec_cfg,
    output kwdt_state_e       state,
    output logic [DATA_W-1:0] cnt,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector
);
    localparam logic [DATA_W-1:0] CNT_MAX = '1;
    localparam logic [DATA_W-1:0] CNT_ONE = 1;

    kwdt_state_e       state_q, state_d;
    logic [DATA_W-1:0] cnt_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [VEC_W-1:0]  vec_q;
    logic              ovf;

    assign ovf = tick && !cnt_we && (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (csr_we && wr_lo[EN_BIT]) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (csr_we && !wr_lo[EN_BIT]) state_d = ST_STOP;
                else if (ovf)                 state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (csr_we && !wr_lo[EN_BIT]) state_d = ST_STOP;
                else if (ovf)                 state_d = ST_FIRE;
                else                          state_d = ST_RUN;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= '0;
            vec_q <= '0;
        end else begin
            if (cnt_we) begin
                cnt_q <= wr_lo;
            end else if (tick) begin
                cnt_q <= cnt_q + CNT_ONE;
            end
            if (ovf) begin
                lvl_q <= prio_cfg[DATA_W-1 -: LVL_W];
                vec_q <= vec_cfg[VEC_W-1:0];
            end
        end
    end

    always_comb begin
        state      = state_q;
        cnt        = cnt_q;
        irq_req    = (state_q == ST_FIRE);
        irq_level  = irq_req ? lvl_q : '0;
        irq_vector = irq_req ? vec_q : '0;
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter int                SEL_W      = 3,
    parameter int                BASE_SHIFT = 5,
    parameter int                EN_BIT     = 5,
    parameter int                LVL_W      = 4,
    parameter int                VEC_W      = 7,
    parameter logic [DATA_W-1:0] KEY_CSR    = 8'hA5,
    parameter logic [DATA_W-1:0] KEY_CNT    = 8'h5A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                wr_en,
    input  logic [2*DATA_W-1:0] wr_data,
    input  logic                rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [DATA_W-1:0]   prio_cfg,
    input  logic [DATA_W-1:0]   vec_cfg,
    output logic                irq_req,
    output logic [LVL_W-1:0]    irq_level,
    output logic [VEC_W-1:0]    irq_vector
);
    logic              csr_we, cnt_we, tick, pre_run;
    logic [DATA_W-1:0] csr_q, cnt_q, wr_lo;
    kwdt_state_e       state;

    assign wr_lo = wr_data[DATA_W-1:0];

    kwdt_keydec #(.DATA_W(DATA_W), .KEY_CSR(KEY_CSR), .KEY_CNT(KEY_CNT)) u_keydec (
        .wr_en  (wr_en),
        .wr_key (wr_data[2*DATA_W-1:DATA_W]),
        .csr_we (csr_we),
        .cnt_we (cnt_we)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else if (csr_we) begin
            csr_q <= wr_lo;
        end
    end

    // A control write suppresses counting on its own edge.
    assign pre_run = (state != ST_STOP) && !csr_we;

    kwdt_prescale #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (pre_run),
        .clr    (csr_we),
        .clk_en (clk_en),
        .sel    (csr_q[SEL_W-1:0]),
        .tick   (tick)
    );

    kwdt_fsm #(.DATA_W(DATA_W), .EN_BIT(EN_BIT), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_we     (csr_we),
        .cnt_we     (cnt_we),
        .wr_lo      (wr_lo),
        .tick       (tick),
        .prio_cfg   (prio_cfg),
        .vec_cfg    (vec_cfg),
        .state      (state),
        .cnt        (cnt_q),
        .irq_req    (irq_req),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    assign rd_data = rd_sel ? cnt_q : csr_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [7:0]  prio_cfg,
    input logic [7:0]  vec_cfg,
    input logic        irq_req,
    input logic [3:0]  irq_level,
    input logic [6:0]  irq_vector,
    input logic [7:0]  csr,
    input logic [7:0]  cnt
);
    p_csr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15:8] == 8'hA5) |=> (csr == $past(wr_data[7:0])));

    p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15:8] == 8'h5A) |=> (cnt == $past(wr_data[7:0])));

    p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15:8] != 8'hA5 && wr_data[15:8] != 8'h5A) |=> $stable(csr));

    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr[5] && !(wr_en && wr_data[15:8] == 8'h5A)) |=> $stable(cnt));

    p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (cnt == 8'h00 && $past(cnt) == 8'hFF));

    p_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_level == $past(prio_cfg[7:4]) && irq_vector == $past(vec_cfg[6:0])));

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_level == 4'd0 && irq_vector == 7'd0));
endmodule

bind keyed_wdt kwdt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .prio_cfg   (prio_cfg),
    .vec_cfg    (vec_cfg),
    .irq_req    (irq_req),
    .irq_level  (irq_level),
    .irq_vector (irq_vector),
    .csr        (csr_q),
    .cnt        (cnt_q)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        rd_sel = 1'b1;
    logic [7:0]  rd_data;
    logic [7:0]  prio_cfg = 8'hB3;
    logic [7:0]  vec_cfg = 8'hC5;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [6:0]  irq_vector;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    keyed_wdt u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .prio_cfg(prio_cfg), .vec_cfg(vec_cfg),
        .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    // Behavioural reference model, updated on each rising edge.
    bit [7:0] m_csr, m_cnt;
    int       m_acc;
    bit       m_fire;
    bit [3:0] m_lvl;
    bit [6:0] m_vec;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_csr = 0; m_cnt = 0; m_acc = 0; m_fire = 0; m_lvl = 0; m_vec = 0;
        end else begin
            bit wcsr, wcnt, tk;
            int period;
            wcsr = wr_en && wr_data[15:8] == 8'hA5;
            wcnt = wr_en && wr_data[15:8] == 8'h5A;
            tk = 0;
            m_fire = 0;
            period = (m_csr[2:0] == 0) ? 2 : (32 << m_csr[2:0]);
            if (wcsr) begin
                m_csr = wr_data[7:0];
                m_acc = 0;
            end else if (m_csr[5] && clk_en) begin
                if (m_acc == period - 1) begin m_acc = 0; tk = 1; end
                else m_acc = m_acc + 1;
            end
            if (wcnt) m_cnt = wr_data[7:0];
            else if (tk) begin
                if (m_cnt == 8'hFF) begin
                    m_cnt = 0; m_fire = 1; m_lvl = prio_cfg[7:4]; m_vec = vec_cfg[6:0];
                end else m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R12 rd_data", rd_data, rd_sel ? m_cnt : m_csr);
            chk("R6 irq_req", irq_req, m_fire);
            chk("R7 irq_level", irq_level, m_fire ? m_lvl : 0);
            chk("R7 irq_vector", irq_vector, m_fire ? m_vec : 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] key, input logic [7:0] lo);
        wr_en = 1'b1; wr_data = {key, lo};
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic rd(input bit sel, output logic [7:0] v);
        rd_sel = sel; #1; v = rd_data; rd_sel = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        rd(1'b0, v); chk("R11 csr after reset", v, 8'h00);
        rd(1'b1, v); chk("R11 cnt after reset", v, 8'h00);
        chk("R11 irq after reset", irq_req, 0);

        // R1, R2, R12: keyed loads and readback (enable clear)
        wr(8'hA5, 8'h07); rd(1'b0, v); chk("R1 csr load", v, 8'h07);
        wr(8'h5A, 8'h3C); rd(1'b1, v); chk("R2 cnt load", v, 8'h3C);
        // R5: disabled, count holds
        wait_n(300); rd(1'b1, v); chk("R5 hold while disabled", v, 8'h3C);
        // R3: wrong keys ignored
        wr(8'h33, 8'h77); wr(8'hA4, 8'h20); wr(8'h5B, 8'h11);
        rd(1'b0, v); chk("R3 csr unchanged", v, 8'h07);
        rd(1'b1, v); chk("R3 cnt unchanged", v, 8'h3C);

        // R4: code 0 -> every 2 cycles
        wr(8'h5A, 8'h00); wr(8'hA5, 8'h20);
        wait_n(20); rd(1'b1, v); chk("R4 code0 period", v, 8'd10);
        // R10: count write on a tick edge wins
        wr(8'hA5, 8'h20); wait_n(1); wr(8'h5A, 8'h10);
        rd(1'b1, v); chk("R10 write beats tick", v, 8'h10);
        wait_n(2); rd(1'b1, v); chk("R10 next tick", v, 8'h11);
        // R9: clk_en low freezes
        clk_en = 1'b0; wait_n(25); rd(1'b1, v); chk("R9 frozen", v, 8'h11);
        clk_en = 1'b1;

        // R4: code 1 -> 64 cycles
        wr(8'h5A, 8'h00); wr(8'hA5, 8'h21);
        wait_n(191); rd(1'b1, v); chk("R4 code1 before third", v, 8'd2);
        wait_n(1); rd(1'b1, v); chk("R4 code1 third", v, 8'd3);
        // R8: control rewrite restarts accumulation
        wait_n(40); wr(8'hA5, 8'h21);
        wait_n(63); rd(1'b1, v); chk("R8 restart hold", v, 8'd3);
        wait_n(1); rd(1'b1, v); chk("R8 restart tick", v, 8'd4);

        // R6, R7: overflow with code 0
        prio_cfg = 8'h9E; vec_cfg = 8'hFF;
        wr(8'h5A, 8'hFF); wr(8'hA5, 8'h20);
        wait_n(2);
        chk("R6 irq pulse", irq_req, 1);
        rd(1'b1, v); chk("R6 wrap to zero", v, 8'h00);
        chk("R7 level", irq_level, 4'h9);
        chk("R7 vector", irq_vector, 7'h7F);
        wait_n(1); chk("R6 pulse one cycle", irq_req, 0);
        chk("R7 level cleared", irq_level, 0);

        // R4, R6, R7: slowest code 7 -> 4096 cycles
        prio_cfg = 8'h5A; vec_cfg = 8'h42;
        wr(8'h5A, 8'hFF); wr(8'hA5, 8'h27);
        wait_n(4095); chk("R4 code7 not yet", irq_req, 0);
        wait_n(1); chk("R6 code7 overflow", irq_req, 1);
        chk("R7 code7 level", irq_level, 4'h5);
        chk("R7 code7 vector", irq_vector, 7'h42);

        // R5: disabling stops counting
        wr(8'hA5, 8'h00); wr(8'h5A, 8'h80);
        wait_n(100); rd(1'b1, v); chk("R5 stopped", v, 8'h80);

        wait_n(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule